// File: doc/BRIEF.md
# Shadowed Nonvolatile RAM Controller

This block holds a word-addressed RAM together with a mirror array of the same depth and word width that stands in for nonvolatile storage. Word i of the RAM always pairs with word i of the mirror. While the supply is reported good and no transfer runs, a host uses the RAM through a plain synchronous port: writes land at the clock edge and reads return one cycle later.

A save copies the whole RAM into the mirror. It starts by itself when the power-good input drops, or on demand when the active-low save request pin falls. A restore copies the whole mirror back into the RAM. It starts by itself when power-good rises again, or on demand when the active-low restore request pin falls. Each transfer walks the addresses upward from zero, one word per clock. The host port is locked out while a transfer runs. A one-cycle completion pulse marks the end of each transfer. The save has a cycle budget, given as a parameter, that models the hold-up time of the supply. A sticky flag records any save that runs past that budget.

Top module: `shadow_nvram`

## Requirements
- R1: After reset, `busy`, `done` and `deadline_miss` are 0 and every RAM word reads as 0.
- R2: When idle with `pwr_good` high, a host access is accepted (`host_ack` = 1 in the same cycle). A write stores `host_wdata` at `host_addr`. A read presents the word on `host_rdata` one cycle later.
- R3: While `busy` is high or `pwr_good` is low, `host_ack` is 0 and a host write leaves the RAM unchanged.
- R4: A falling edge on `save_req_n` while idle starts a save. `busy` rises on the next cycle and stays high for exactly DEPTH cycles. During those cycles word i of the RAM is copied into word i of the mirror, for i = 0 up to DEPTH-1.
- R5: A falling edge on `restore_req_n` while idle starts a restore. It has the same timing as R4 and copies every mirror word into the RAM word with the same address.
- R6: A falling edge on `pwr_good` while idle starts a save with R4 timing.
- R7: A rising edge on `pwr_good` while idle starts a restore with R5 timing.
- R8: When a save trigger and a restore trigger occur in the same cycle, only the save runs and no restore follows it.
- R9: Trigger edges that occur while `busy` is high are discarded. `busy` stays low after the running transfer ends.
- R10: `done` is high for exactly one cycle, in the first cycle after `busy` falls, and never while `busy` is high.
- R11: `deadline_miss` is set during a save once the save has used SAVE_BUDGET cycles without finishing, so it is set whenever DEPTH > SAVE_BUDGET. It then stays set until reset. With SAVE_BUDGET >= DEPTH it never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply good; falling edge saves, rising edge restores |
| save_req_n | input | 1 | Active-low save request, acts on its falling edge |
| restore_req_n | input | 1 | Active-low restore request, acts on its falling edge |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write when high |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_ack | output | 1 | Host access accepted this cycle |
| host_rdata | output | DATA_W | Read data, one cycle after an accepted read |
| busy | output | 1 | A save or restore is running |
| done | output | 1 | One-cycle pulse after a transfer completes |
| deadline_miss | output | 1 | Sticky: a save exceeded SAVE_BUDGET cycles |

## Verification
On every clock, the assertions check several rules. The host is refused while busy or while power is low. Each power or request edge that arrives while idle leads to `busy` in the following cycle. `done` is a single pulse that lines up with the fall of `busy`. The overrun flag never clears once set, and it never sets when the budget covers the whole depth. Only the bench scenarios can show what the arrays hold. The bench writes the RAM, saves it, overwrites the RAM, restores it and reads it back. This shows that every word travels in the right direction, that a save wins over a simultaneous restore, that a trigger arriving mid-transfer leaves no trailing transfer, and that the overrun flag rises on a short-budget instance.

// File: rtl/snv_pkg.sv
// Shared types for the shadowed nonvolatile RAM controller.
package snv_pkg;
    // Transfer sequencer state: idle, RAM-to-mirror, mirror-to-RAM.
    typedef enum logic [1:0] {
        XF_IDLE    = 2'd0,
        XF_SAVE    = 2'd1,
        XF_RESTORE = 2'd2
    } xfer_t;
endpackage

// File: rtl/snv_trigger.sv
// Detects the save and restore trigger edges and arbitrates between them.
// Assumes inputs are synchronous to clk. The edge registers reset to the
// inactive level, so power that is already good at reset starts nothing.
// Save wins over restore. Triggers are passed on only when the sequencer is idle.
module snv_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic pwr_good,
    input  logic save_req_n,
    input  logic restore_req_n,
    output logic start_save,
    output logic start_restore
);
    logic pwr_q;
    logic sv_q;
    logic rs_q;
    logic want_save;
    logic want_restore;

    // Hold last-cycle levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= 1'b1;
            sv_q  <= 1'b1;
            rs_q  <= 1'b1;
        end else begin
            pwr_q <= pwr_good;
            sv_q  <= save_req_n;
            rs_q  <= restore_req_n;
        end
    end

    // Combine sources and apply save-over-restore priority.
    always_comb begin
        want_save     = (sv_q & ~save_req_n) | (pwr_q & ~pwr_good);
        want_restore  = (rs_q & ~restore_req_n) | (~pwr_q & pwr_good);
        start_save    = idle & want_save;
        start_restore = idle & want_restore & ~want_save;
    end
endmodule

// File: rtl/snv_xfer_ctrl.sv
// Sequencer for whole-array transfers. It steps one word per cycle from
// address 0 to DEPTH-1, pulses done after the last word, and flags a save
// that outlives SAVE_BUDGET cycles. Assumes DEPTH is a power of two.
module snv_xfer_ctrl
    import snv_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SAVE_BUDGET = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_save,
    input  logic              start_restore,
    output xfer_t             state,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic              deadline_miss
);
    localparam int unsigned DEPTH    = 1 << ADDR_W;
    localparam bit          CAN_MISS = (SAVE_BUDGET < DEPTH);

    logic last;
    logic over;

    // Detect the final word and the budget overrun point.
    always_comb begin
        last = &addr;
        over = CAN_MISS && (state == XF_SAVE) && (32'(addr) >= SAVE_BUDGET);
    end

    // Sequencer state and walking address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= XF_IDLE;
            addr  <= '0;
        end else begin
            unique case (state)
                XF_IDLE: begin
                    addr <= '0;
                    if (start_save)         state <= XF_SAVE;
                    else if (start_restore) state <= XF_RESTORE;
                end
                default: begin
                    addr <= addr + 1'b1;
                    if (last) state <= XF_IDLE;
                end
            endcase
        end
    end

    // Completion pulse and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done          <= 1'b0;
            deadline_miss <= 1'b0;
        end else begin
            done <= (state != XF_IDLE) && last;
            if (over) deadline_miss <= 1'b1;
        end
    end
endmodule

// File: rtl/snv_arrays.sv
// The volatile RAM, its nonvolatile mirror, and the host port. The host is
// served only when idle and powered. The sequencer address drives the
// copy in either direction. The mirror has no reset, because it models storage
// that survives one.
module snv_arrays
    import snv_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xfer_t             state,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic              pwr_good,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram    [DEPTH];
    logic [DATA_W-1:0] mirror [DEPTH];

    // Host acceptance gate.
    always_comb host_ack = host_en & pwr_good & (state == XF_IDLE);

    // RAM: cleared by reset, written by the host or by a restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
        end else if (host_ack && host_we) begin
            ram[host_addr] <= host_wdata;
        end else if (state == XF_RESTORE) begin
            ram[xfer_addr] <= mirror[xfer_addr];
        end
    end

    // Mirror: written only by a save.
    always_ff @(posedge clk) begin
        if (state == XF_SAVE) mirror[xfer_addr] <= ram[xfer_addr];
    end

    // Registered host read data.
    always_ff @(posedge clk) begin
        if (!rst_n)                  host_rdata <= '0;
        else if (host_ack && !host_we) host_rdata <= ram[host_addr];
    end
endmodule

// File: rtl/shadow_nvram.sv
// Top level of the shadowed nonvolatile RAM controller: trigger detection,
// transfer sequencer and the two arrays. SAVE_BUDGET is the save time
// limit in clock cycles.
module shadow_nvram
    import snv_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SAVE_BUDGET = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              save_req_n,
    input  logic              restore_req_n,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              busy,
    output logic              done,
    output logic              deadline_miss
);
    xfer_t             state;
    logic [ADDR_W-1:0] xfer_addr;
    logic              start_save;
    logic              start_restore;

    // Busy whenever the sequencer is not idle.
    always_comb busy = (state != XF_IDLE);

    snv_trigger u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle         (~busy),
        .pwr_good     (pwr_good),
        .save_req_n   (save_req_n),
        .restore_req_n(restore_req_n),
        .start_save   (start_save),
        .start_restore(start_restore)
    );

    snv_xfer_ctrl #(.ADDR_W(ADDR_W), .SAVE_BUDGET(SAVE_BUDGET)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_save   (start_save),
        .start_restore(start_restore),
        .state        (state),
        .addr         (xfer_addr),
        .done         (done),
        .deadline_miss(deadline_miss)
    );

    snv_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .xfer_addr (xfer_addr),
        .pwr_good  (pwr_good),
        .host_en   (host_en),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_ack  (host_ack),
        .host_rdata(host_rdata)
    );
endmodule

// File: rtl/snv_checker.sv
// Port-level temporal checks for shadow_nvram, attached by bind.
module snv_checker #(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SAVE_BUDGET = 32
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic save_req_n,
    input logic restore_req_n,
    input logic host_ack,
    input logic busy,
    input logic done,
    input logic deadline_miss
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    assert_busy_refuses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !host_ack);
    assert_unpowered_refuses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> !host_ack);
    assert_save_req_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $fell(save_req_n)) |=> busy);
    assert_restore_req_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $fell(restore_req_n)) |=> busy);
    assert_power_fail_saves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $fell(pwr_good)) |=> busy);
    assert_power_back_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $rose(pwr_good)) |=> busy);
    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_miss_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        deadline_miss |=> deadline_miss);

    generate
        if (SAVE_BUDGET >= DEPTH) begin : g_no_miss
            assert_never_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
                !deadline_miss);
        end
    endgenerate
endmodule

bind shadow_nvram snv_checker #(.ADDR_W(ADDR_W), .SAVE_BUDGET(SAVE_BUDGET)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .save_req_n   (save_req_n),
    .restore_req_n(restore_req_n),
    .host_ack     (host_ack),
    .busy         (busy),
    .done         (done),
    .deadline_miss(deadline_miss)
);

// File: tb/shadow_nvram_tb.sv
`timescale 1ns/1ps
module shadow_nvram_tb;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b1;
    logic save_req_n = 1'b1;
    logic restore_req_n = 1'b1;
    logic host_en = 1'b0;
    logic host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic host_ack, busy, done, deadline_miss;
    logic [DW-1:0] host_rdata;
    logic s_ack, s_busy, s_done, s_miss;
    logic [DW-1:0] s_rdata;

    int nchk = 0;
    int nfail = 0;
    logic [DW-1:0] ram_m [DEPTH];
    logic [DW-1:0] nv_m  [DEPTH];

    always #2 clk = ~clk;

    shadow_nvram #(.ADDR_W(AW), .DATA_W(DW), .SAVE_BUDGET(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .save_req_n(save_req_n),
        .restore_req_n(restore_req_n), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .busy(busy), .done(done), .deadline_miss(deadline_miss));

    shadow_nvram #(.ADDR_W(AW), .DATA_W(DW), .SAVE_BUDGET(8)) u_dut_short (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .save_req_n(save_req_n),
        .restore_req_n(restore_req_n), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(s_ack),
        .host_rdata(s_rdata), .busy(s_busy), .done(s_done), .deadline_miss(s_miss));

    function automatic logic [DW-1:0] pattern(input int a, input int salt);
        return DW'((a * 37 + salt * 11 + 5) ^ (salt << 3));
    endfunction

    function automatic logic [DW-1:0] expect_word(input int a);
        return ram_m[a];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    endtask

    task automatic hwrite(input int a, input logic [DW-1:0] d, output bit ack);
        host_en = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        #1 ack = host_ack;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic hread(input int a, output logic [DW-1:0] d, output bit ack);
        host_en = 1'b1; host_we = 1'b0; host_addr = AW'(a);
        #1 ack = host_ack;
        @(negedge clk);
        host_en = 1'b0;
        d = host_rdata;
    endtask

    // Count busy cycles from the current negedge, then sample done.
    task automatic wait_xfer(input string tag);
        int n = 0;
        while (busy && n < 4 * DEPTH) begin
            n++;
            @(negedge clk);
        end
        chk(n == DEPTH, {tag, " busy length"}, n, DEPTH);
        chk(done === 1'b1, "R10 done pulse", int'(done), 1);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", int'(done), 0);
    endtask

    task automatic pulse(input bit sv, input bit rs);
        save_req_n = ~sv; restore_req_n = ~rs;
        @(negedge clk);
        save_req_n = 1'b1; restore_req_n = 1'b1;
    endtask

    task automatic fill(input int salt);
        bit ack;
        for (int a = 0; a < DEPTH; a++) begin
            hwrite(a, pattern(a, salt), ack);
            chk(ack, "R2 write ack", int'(ack), 1);
            ram_m[a] = pattern(a, salt);
        end
    endtask

    task automatic check_all(input string tag);
        logic [DW-1:0] d;
        bit ack;
        for (int a = 0; a < DEPTH; a++) begin
            hread(a, d, ack);
            chk(ack && d == expect_word(a), tag, int'(d), int'(expect_word(a)));
        end
    endtask

    task automatic do_save_req();
        pulse(1'b1, 1'b0);
        wait_xfer("R4");
        for (int a = 0; a < DEPTH; a++) nv_m[a] = ram_m[a];
    endtask

    task automatic do_restore_req();
        pulse(1'b0, 1'b1);
        wait_xfer("R5");
        for (int a = 0; a < DEPTH; a++) ram_m[a] = nv_m[a];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic [DW-1:0] d;
        bit ack;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < DEPTH; a++) ram_m[a] = '0;

        // R1 reset state
        chk(!busy && !done && !deadline_miss && !s_miss, "R1 status after reset", int'(busy), 0);
        check_all("R1 zero after reset");

        // R2 plain RAM use
        fill(1);
        check_all("R2 readback");

        // R4 save, R11 budget flag
        do_save_req();
        chk(deadline_miss == 1'b0, "R11 no miss with ample budget", int'(deadline_miss), 0);
        chk(s_miss == 1'b1, "R11 miss on short budget", int'(s_miss), 1);

        // R5 restore brings back saved image
        fill(2);
        do_restore_req();
        check_all("R5 restored image");
        chk(s_miss == 1'b1, "R11 miss stays set", int'(s_miss), 1);

        // R3 write during a save is refused and has no effect
        fill(3);
        save_req_n = 1'b0;
        @(negedge clk);
        save_req_n = 1'b1;
        hwrite(4, 8'hA5, ack);
        chk(!ack, "R3 refused while busy", int'(ack), 0);
        while (busy) @(negedge clk);
        @(negedge clk);
        for (int a = 0; a < DEPTH; a++) nv_m[a] = ram_m[a];
        check_all("R3 RAM unchanged by refused write");

        // R6/R7 power cycle
        fill(4);
        pwr_good = 1'b0;
        @(negedge clk);
        wait_xfer("R6");
        for (int a = 0; a < DEPTH; a++) nv_m[a] = ram_m[a];
        hwrite(2, 8'h3C, ack);
        chk(!ack, "R3 refused while unpowered", int'(ack), 0);
        pwr_good = 1'b1;
        @(negedge clk);
        wait_xfer("R7");
        check_all("R7 contents after power cycle");
        fill(5);
        do_restore_req();
        check_all("R6 power-fail image saved");

        // R8 simultaneous triggers: save only
        fill(6);
        pulse(1'b1, 1'b1);
        wait_xfer("R8");
        for (int a = 0; a < DEPTH; a++) nv_m[a] = ram_m[a];
        repeat (2) begin
            chk(!busy, "R8 no trailing restore", int'(busy), 0);
            @(negedge clk);
        end
        check_all("R8 RAM kept by save");

        // R9 trigger mid-transfer ignored
        fill(7);
        restore_req_n = 1'b0;
        @(negedge clk);
        restore_req_n = 1'b1;
        save_req_n = 1'b0;
        @(negedge clk);
        save_req_n = 1'b1;
        while (busy) @(negedge clk);
        @(negedge clk);
        for (int a = 0; a < DEPTH; a++) ram_m[a] = nv_m[a];
        repeat (3) begin
            chk(!busy, "R9 late trigger dropped", int'(busy), 0);
            @(negedge clk);
        end
        check_all("R9 restore result");

        // Random mix checked against the bench model
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom % 20);
            int a  = int'($urandom % DEPTH);
            if (op < 11) begin
                logic [DW-1:0] v = DW'($urandom);
                hwrite(a, v, ack);
                chk(ack, "R2 random write ack", int'(ack), 1);
                ram_m[a] = v;
            end else if (op < 18) begin
                hread(a, d, ack);
                chk(ack && d == expect_word(a), "R2 random read", int'(d), int'(expect_word(a)));
            end else if (op == 18) begin
                do_save_req();
            end else begin
                do_restore_req();
            end
        end
        check_all("R5 final image");
        summary();
    end
endmodule